// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block holds the power configuration register and the sequencer for the two reduced-activity states. Software writes the register over a simple write strobe. Setting the idle bit stops only the CPU clock, and the peripherals and interrupt logic keep running. Setting the power-down bit stops every clock and also turns off the oscillator. The block itself runs from an always-on reference clock, so that it can count and watch wake sources while the main oscillator is off.

Idle ends on any enabled interrupt. Power-down ends only when an armed, level-sensitive external interrupt line is driven low. The oscillator is then restarted, and a programmable settle count must expire before the peripheral clock returns. The CPU clock returns only after every armed external line has been released. Each return to normal running produces a one-cycle resume pulse. An asynchronous reset clears the mode bits and restores all clock enables without waiting for an edge.

There is no data stream: all pins are plain control and status levels, with no valid/ready handshake and no back-pressure.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00, `cpu_clk_en`, `per_clk_en` and `osc_en` are 1 and `resume_pulse` is 0. Register bits 7..4 are reserved and always read 0, whatever is written to them.
- R2: A write in the running state with bit 1 (power-down, mask 0x02) set drops `cpu_clk_en`, `per_clk_en` and `osc_en` to 0 on the next edge, whatever bit 0 holds. The write stores both bits. After the wake-up that follows, the block returns to running and not to idle.
- R3: A write in the running state with bit 0 (idle, mask 0x01) set and bit 1 clear drops only `cpu_clk_en` on the next edge. `per_clk_en` and `osc_en` stay 1.
- R4: In idle, `irq_wake` high at an edge restores `cpu_clk_en` after that edge, clears bit 0, and raises `resume_pulse` for exactly one cycle.
- R5: In power-down, `irq_wake` has no effect. A low external line whose `ext_arm` bit is 0 also has no effect. All three enables stay 0.
- R6: In power-down, an external line that is armed and low (active low) at an edge sets `osc_en` after that edge and clears bits 0 and 1. `per_clk_en` returns on the (N+1)-th edge after the waking edge, where N is `settle_count`.
- R7: After the settle count expires, `cpu_clk_en` stays 0 while any armed external line is low. On the first edge at which all armed lines are high, it returns to 1 and `resume_pulse` is high for one cycle.
- R8: `rst` high clears the register's low nibble and sets the three enables to 1 immediately, without a clock edge.
- R9: Bits 2 and 3 are general-purpose flags. Software writes them, and no hardware event (idle wake or power-down wake) changes them.
- R10: Register writes made while the block is not in the running state are ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Asynchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read value |
| irq_wake | input | 1 | An enabled interrupt is pending |
| ext_irq_n | input | NUM_XINT (2) | External interrupt lines, active low |
| ext_arm | input | NUM_XINT (2) | Per line: enabled and level-sensitive, may wake from power-down |
| settle_count | input | SETTLE_W (8) | Oscillator settle length in cycles |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| resume_pulse | output | 1 | One-cycle pulse on return to running |

## Verification
Every registered result is due on the first edge after the stimulus that causes it: mode entry after the write, the idle exit and the oscillator restart after the wake sample, and the CPU clock after the release. The peripheral clock is the exception: it comes back settle_count+1 edges after the waking edge. When the driver applies a stimulus, it pushes the expected output snapshot into a queue tagged with the exact cycle it is due. The monitor compares the snapshot at the falling edge of that cycle, and holds of several cycles are checked cycle by cycle. The asynchronous reset is the only result checked between edges, a few time units after `rst` rises.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  localparam int CFG_W   = 8;
  localparam int BIT_IDL = 0;
  localparam int BIT_PD  = 1;
  localparam int GP_LO   = 2;
  localparam int GP_HI   = 3;
  localparam int LIVE_W  = GP_HI + 1;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_PDOWN  = 3'd2,
    ST_SETTLE = 3'd3,
    ST_HOLD   = 3'd4
  } pm_state_e;
endpackage

// File: rtl/pwrmode_cfg_reg.sv
module pwrmode_cfg_reg
  import pwrmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic             clr_idle,
  input  logic             clr_pd,
  output logic [CFG_W-1:0] rdata,
  output logic             idle_q,
  output logic             pd_q
);
  localparam int GP_W = GP_HI - GP_LO + 1;

  logic [GP_W-1:0] gp_q;
  logic            unused_rsvd;

  assign unused_rsvd = ^wdata[CFG_W-1:LIVE_W];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
      gp_q   <= '0;
    end else begin
      if (wr_en) begin
        idle_q <= wdata[BIT_IDL];
        pd_q   <= wdata[BIT_PD];
        gp_q   <= wdata[GP_HI:GP_LO];
      end
      if (clr_pd) begin
        idle_q <= 1'b0;
        pd_q   <= 1'b0;
      end
      if (clr_idle) idle_q <= 1'b0;
    end
  end

  always_comb begin
    rdata                = '0;
    rdata[BIT_IDL]       = idle_q;
    rdata[BIT_PD]        = pd_q;
    rdata[GP_HI:GP_LO]   = gp_q;
  end

  AST_GP_HW_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(gp_q)); // R9

  AST_PD_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_pd && !wr_en) |=> (!pd_q && !idle_q)); // R6
endmodule

// File: rtl/pwrmode_settle.sv
module pwrmode_settle #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  AST_SETTLE_LOADED: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val))); // R6

  AST_SETTLE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && !load && done) |=> done); // R6
endmodule

// File: rtl/pwrmode_fsm.sv
module pwrmode_fsm
  import pwrmode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_we,
  input  logic      wr_idle,
  input  logic      wr_pd,
  input  logic      irq_wake,
  input  logic      ext_act,
  input  logic      cnt_done,
  output logic      wr_accept,
  output logic      clr_idle,
  output logic      clr_pd,
  output logic      cnt_load,
  output logic      cnt_run,
  output logic      cpu_en,
  output logic      per_en,
  output logic      osc_en,
  output logic      resume_q
);
  pm_state_e st_q, st_nxt;

  always_comb begin
    st_nxt    = st_q;
    clr_idle  = 1'b0;
    clr_pd    = 1'b0;
    cnt_load  = 1'b0;
    wr_accept = cfg_we && (st_q == ST_RUN);
    case (st_q)
      ST_RUN: begin
        if (wr_accept && wr_pd)        st_nxt = ST_PDOWN;
        else if (wr_accept && wr_idle) st_nxt = ST_IDLE;
      end
      ST_IDLE: begin
        if (irq_wake) begin
          st_nxt   = ST_RUN;
          clr_idle = 1'b1;
        end
      end
      ST_PDOWN: begin
        if (ext_act) begin
          st_nxt   = ST_SETTLE;
          clr_pd   = 1'b1;
          cnt_load = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cnt_done) st_nxt = ST_HOLD;
      end
      ST_HOLD: begin
        if (!ext_act) st_nxt = ST_RUN;
      end
      default: st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st_q     <= ST_RUN;
      resume_q <= 1'b0;
    end else begin
      st_q     <= st_nxt;
      resume_q <= (st_nxt == ST_RUN) && (st_q == ST_IDLE || st_q == ST_HOLD);
    end
  end

  assign cnt_run = (st_q == ST_SETTLE);
  assign cpu_en  = (st_q == ST_RUN);
  assign per_en  = (st_q == ST_RUN) || (st_q == ST_IDLE) || (st_q == ST_HOLD);
  assign osc_en  = (st_q != ST_PDOWN);

  AST_PD_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_accept && wr_pd) |=> (st_q == ST_PDOWN)); // R2

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (wr_accept && wr_idle && !wr_pd) |=> (st_q == ST_IDLE)); // R3

  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && irq_wake) |=> (st_q == ST_RUN && resume_q)); // R4

  AST_PD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PDOWN && !ext_act) |=> (st_q == ST_PDOWN)); // R5

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && ext_act) |=> (st_q == ST_HOLD)); // R7

  AST_NO_WRITE_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && st_q != ST_RUN) |-> !wr_accept); // R10
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int SETTLE_W = 8,
  parameter int NUM_XINT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  input  logic                irq_wake,
  input  logic [NUM_XINT-1:0] ext_irq_n,
  input  logic [NUM_XINT-1:0] ext_arm,
  input  logic [SETTLE_W-1:0] settle_count,
  output logic                cpu_clk_en,
  output logic                per_clk_en,
  output logic                osc_en,
  output logic                resume_pulse
);
  logic [NUM_XINT-1:0] line_act;
  logic ext_act, wr_accept, clr_idle, clr_pd;
  logic cnt_load, cnt_run, cnt_done;
  logic idle_q, pd_q;

  for (genvar i = 0; i < NUM_XINT; i++) begin : g_xint
    assign line_act[i] = ext_arm[i] & ~ext_irq_n[i];
  end
  assign ext_act = |line_act;

  pwrmode_cfg_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_accept),
    .wdata    (cfg_wdata),
    .clr_idle (clr_idle),
    .clr_pd   (clr_pd),
    .rdata    (cfg_rdata),
    .idle_q   (idle_q),
    .pd_q     (pd_q)
  );

  pwrmode_settle #(.CNT_W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (settle_count),
    .run      (cnt_run),
    .done     (cnt_done)
  );

  pwrmode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .wr_idle   (cfg_wdata[BIT_IDL]),
    .wr_pd     (cfg_wdata[BIT_PD]),
    .irq_wake  (irq_wake),
    .ext_act   (ext_act),
    .cnt_done  (cnt_done),
    .wr_accept (wr_accept),
    .clr_idle  (clr_idle),
    .clr_pd    (clr_pd),
    .cnt_load  (cnt_load),
    .cnt_run   (cnt_run),
    .cpu_en    (cpu_clk_en),
    .per_en    (per_clk_en),
    .osc_en    (osc_en),
    .resume_q  (resume_pulse)
  );

  AST_CPU_NEEDS_PER: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> (per_clk_en && osc_en)); // R3

  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |=> !resume_pulse); // R4

  AST_PD_BIT_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    pd_q |-> !cpu_clk_en); // R2

  AST_IDLE_BIT_CPU: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> !cpu_clk_en); // R3
endmodule

// File: tb/pwrmode_ctrl_tb.sv
module pwrmode_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          due;
    logic [11:0] snap;
    string       req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       irq_wake = 1'b0;
  logic [1:0] ext_irq_n = 2'b11;
  logic [1:0] ext_arm = 2'b00;
  logic [7:0] settle_count = 8'd0;
  logic       cpu_clk_en, per_clk_en, osc_en, resume_pulse;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwrmode_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_wake(irq_wake), .ext_irq_n(ext_irq_n),
    .ext_arm(ext_arm), .settle_count(settle_count), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .resume_pulse(resume_pulse)
  );

  function automatic logic [11:0] now_snap();
    return {cpu_clk_en, per_clk_en, osc_en, resume_pulse, cfg_rdata};
  endfunction

  task automatic compare(input logic [11:0] got, input logic [11:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d got cpu/per/osc/res=%b rdata=%h expected %b rdata=%h",
               req, cyc, got[11:8], got[7:0], exp[11:8], exp[7:0]);
    end
  endtask

  // driver side: expected snapshot due n edges from now
  task automatic expect_in(input int n, input logic [3:0] en, input logic [7:0] rd, input string req);
    exp_t e;
    e.due  = cyc + n;
    e.snap = {en, rd};
    e.req  = req;
    sb.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] d);
    cfg_we = 1'b1;
    cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  // monitor: pops expected items on their due cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (e.due < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s missed due cycle %0d got none expected %h", e.req, e.due, e.snap);
      end else begin
        compare(now_snap(), e.snap, e.req);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) tick();
    rst = 1'b0;
    expect_in(1, 4'b1110, 8'h00, "R1 reset state");
    tick();

    // R9 / R1: flags written, reserved bits read zero
    expect_in(1, 4'b1110, 8'h0C, "R9 gp flags write, R1 reserved zero");
    reg_write(8'hFC);

    // R3: idle entry
    expect_in(1, 4'b0110, 8'h0D, "R3 idle stops cpu only");
    reg_write(8'h0D);

    // R10: write while idle ignored
    expect_in(1, 4'b0110, 8'h0D, "R10 write in idle ignored");
    reg_write(8'h02);
    expect_in(1, 4'b0110, 8'h0D, "R10 idle held after ignored write");
    tick();

    // R4: idle wake
    irq_wake = 1'b1;
    expect_in(1, 4'b1111, 8'h0C, "R4 idle wake with pulse");
    tick();
    irq_wake = 1'b0;
    expect_in(1, 4'b1110, 8'h0C, "R4 pulse one cycle");
    tick();

    // R2: both bits -> power-down
    expect_in(1, 4'b0000, 8'h0B, "R2 power-down wins over idle");
    reg_write(8'h0B);

    // R5: irq_wake and unarmed line ignored
    irq_wake = 1'b1;
    ext_irq_n = 2'b10;
    ext_arm = 2'b10;
    for (int k = 1; k <= 3; k++) begin
      expect_in(1, 4'b0000, 8'h0B, "R5 power-down ignores wake sources");
      tick();
    end
    irq_wake = 1'b0;
    ext_irq_n = 2'b11;
    ext_arm = 2'b01;
    expect_in(1, 4'b0000, 8'h0B, "R5 released lines keep power-down");
    tick();

    // R6/R7: armed line 0 low, settle 3, held long
    settle_count = 8'd3;
    ext_irq_n = 2'b10;
    expect_in(1, 4'b0010, 8'h08, "R6 osc restarts bits cleared");
    expect_in(4, 4'b0010, 8'h08, "R6 per off during settle");
    expect_in(5, 4'b0110, 8'h08, "R6 per back after settle+1");
    expect_in(6, 4'b0110, 8'h08, "R7 cpu held while line low");
    expect_in(7, 4'b0110, 8'h08, "R7 cpu still held");
    repeat (7) tick();
    ext_irq_n = 2'b11;
    expect_in(1, 4'b1111, 8'h08, "R7 release resumes, R2 not idle, R9 flag kept");
    expect_in(2, 4'b1110, 8'h08, "R7 pulse one cycle");
    repeat (2) tick();

    // R6/R7: settle 0, line 1 short pulse
    settle_count = 8'd0;
    ext_arm = 2'b10;
    expect_in(1, 4'b0000, 8'h0A, "R2 power-down only bit");
    reg_write(8'h0A);
    ext_irq_n = 2'b01;
    expect_in(1, 4'b0010, 8'h08, "R6 line1 wake settle0");
    tick();
    ext_irq_n = 2'b11;
    expect_in(1, 4'b0110, 8'h08, "R6 per after one edge");
    expect_in(2, 4'b1111, 8'h08, "R7 resume after release");
    repeat (3) tick();

    // R8: asynchronous reset from idle
    expect_in(1, 4'b0110, 8'h09, "R3 idle before async reset");
    reg_write(8'h09);
    #(CLK_PERIOD/4);
    rst = 1'b1;
    #1;
    compare(now_snap(), {4'b1110, 8'h00}, "R8 async reset clears without edge");
    tick();
    rst = 1'b0;
    tick();

    while (sb.size() > 0) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule